// File: doc/BRIEF.md
# Address Table Violation Capture Unit

The block sits beside an address-table datapath and records the problems that datapath reports: an entry aged out, a frame from a port that is not a member, a lookup miss, and a table with no free slot. Each problem arrives as a one-cycle pulse on one or more kind lines. The pulse comes with the MAC address, the port vector and the number of the source port. A pending problem raises a level interrupt. The host services it with a get-and-clear command, which follows the same busy handshake as the other table commands. Once busy falls, the host reads the kind flags and the captured fields.

There are two holding slots. The oldest event is the one reported, and a second event waits behind it. A further event that arrives while both slots are full is discarded and sets a sticky overflow indication. Pulses on several kind lines in the same cycle form one event with all of those flags set.

Top module: `atu_viol_capture`

## Requirements
- R1: After reset, irq_o, busy_o and ovf_o are 0 and every result output (flags_o, mac_o, pvec_o, spid_o) is 0.
- R2: Any nonzero viol_kind_i in a cycle makes irq_o high from the next cycle.
- R3: cmd_i seen while busy_o is 0 drives busy_o high from the next cycle for exactly CMD_LAT cycles. cmd_i seen while busy_o is 1 has no effect.
- R4: In the cycle busy_o falls, the results show the oldest pending event. flags_o bit 0 is age-out, bit 1 is member, bit 2 is miss and bit 3 is table-full. mac_o, pvec_o and spid_o carry that event's fields, and spid_o is the 4-bit source port number.
- R5: Pulses on several viol_kind_i bits in one cycle form a single event, reported with all of those flag bits set.
- R6: An event that arrives while one is pending is held. It is reported by the next command, and irq_o stays high until it has been reported.
- R7: An event that arrives while two events are held is dropped. ovf_o then goes high and stays high until reset.
- R8: irq_o falls in the cycle busy_o falls when no further event is held and none arrives in the completing cycle.
- R9: A command that completes with nothing pending returns all-zero flags and fields.
- R10: The result outputs change only in the cycle busy_o falls.
- R11: An event that arrives in the same cycle as a command completes is kept, and the next command reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| viol_kind_i | input | 4 | One-cycle violation pulses: 0 age-out, 1 member, 2 miss, 3 full |
| viol_mac_i | input | 48 | MAC address of the offending frame |
| viol_pvec_i | input | 11 | Port vector of the offending entry |
| viol_spid_i | input | 4 | Source port number of the offending frame |
| cmd_i | input | 1 | Get-and-clear command request |
| busy_o | output | 1 | Command in progress; results are valid once it is low |
| irq_o | output | 1 | Level interrupt, high while an event is held |
| flags_o | output | 4 | Kind flags of the reported event |
| mac_o | output | 48 | Reported MAC address |
| pvec_o | output | 11 | Reported port vector |
| spid_o | output | 4 | Reported source port number |
| ovf_o | output | 1 | Sticky overflow indication |

## Verification
A wrong slot pointer or a wrong valid bit shows up on the ports at the next command completion. The visible symptoms are a wrong or repeated event, stale zero fields, or irq_o staying high or falling a command too early. A wrong busy counter moves the fall of busy_o away from the CMD_LAT-cycle window, so every completion exposes it. An overflow or merge fault shows up within one cycle on ovf_o, or at the next read-out as a missing flag bit.

// File: rtl/atu_viol_pkg.sv
package atu_viol_pkg;
  localparam int unsigned KIND_N = 4;
  localparam int unsigned MAC_W  = 48;
  localparam int unsigned PVEC_W = 11;
  localparam int unsigned SPID_W = 4;

  typedef struct packed {
    logic [KIND_N-1:0] kinds;
    logic [MAC_W-1:0]  mac;
    logic [PVEC_W-1:0] pvec;
    logic [SPID_W-1:0] spid;
  } viol_ev_t;
endpackage

// File: rtl/atu_viol_merge.sv
module atu_viol_merge
  import atu_viol_pkg::*;
(
  input  logic [KIND_N-1:0] kind_i,
  input  logic [MAC_W-1:0]  mac_i,
  input  logic [PVEC_W-1:0] pvec_i,
  input  logic [SPID_W-1:0] spid_i,
  output logic              push_o,
  output viol_ev_t          ev_o
);
  // simultaneous pulses share one field set and become a single event
  assign push_o   = |kind_i;
  assign ev_o     = '{kinds: kind_i, mac: mac_i, pvec: pvec_i, spid: spid_i};
endmodule

// File: rtl/atu_viol_queue.sv
module atu_viol_queue
  import atu_viol_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  viol_ev_t ev_i,
  input  logic     pop_i,
  output logic     head_vld_o,
  output viol_ev_t head_o,
  output logic     ovf_o
);
  viol_ev_t head_q, tail_q, head_d, tail_d;
  logic     v0_q, v1_q, v0_d, v1_d, ovf_q, ovf_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    v0_d   = v0_q;
    v1_d   = v1_q;
    ovf_d  = ovf_q;
    if (pop_i) begin
      head_d = tail_q;
      v0_d   = v1_q;
      v1_d   = 1'b0;
    end
    // push lands in the slot freed by a same-cycle pop
    if (push_i) begin
      if (!v0_d) begin
        head_d = ev_i;
        v0_d   = 1'b1;
      end else if (!v1_d) begin
        tail_d = ev_i;
        v1_d   = 1'b1;
      end else begin
        ovf_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      v0_q   <= 1'b0;
      v1_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      v0_q   <= v0_d;
      v1_q   <= v1_d;
      ovf_q  <= ovf_d;
    end
  end

  assign head_vld_o = v0_q;
  assign head_o     = head_q;
  assign ovf_o      = ovf_q;

  p_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) v1_q |-> v0_q);
  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_q |=> ovf_q);
  p_ovf_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(v0_q && v1_q));
endmodule

// File: rtl/atu_viol_cmd.sv
module atu_viol_cmd
  import atu_viol_pkg::*;
#(
  parameter int unsigned CMD_LAT = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_i,
  input  logic     head_vld_i,
  input  viol_ev_t head_i,
  output logic     busy_o,
  output logic     pop_o,
  output viol_ev_t res_o
);
  localparam int unsigned CNT_W = $clog2(CMD_LAT + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  viol_ev_t         res_q;

  assign pop_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
    end else if (!busy_q) begin
      if (cmd_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(CMD_LAT - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
      res_q  <= head_vld_i ? head_i : '0;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign res_o  = res_q;

  p_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd_i && !busy_q |=> busy_q);
  p_res_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_q |=> $stable(res_q));
  p_empty_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o && !head_vld_i |=> (res_q == '0));
endmodule

// File: rtl/atu_viol_capture.sv
module atu_viol_capture
  import atu_viol_pkg::*;
#(
  parameter int unsigned CMD_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [KIND_N-1:0] viol_kind_i,
  input  logic [MAC_W-1:0]  viol_mac_i,
  input  logic [PVEC_W-1:0] viol_pvec_i,
  input  logic [SPID_W-1:0] viol_spid_i,
  input  logic              cmd_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic [KIND_N-1:0] flags_o,
  output logic [MAC_W-1:0]  mac_o,
  output logic [PVEC_W-1:0] pvec_o,
  output logic [SPID_W-1:0] spid_o,
  output logic              ovf_o
);
  logic     push, pop, head_vld;
  viol_ev_t ev, head, res;

  atu_viol_merge u_merge (
    .kind_i (viol_kind_i),
    .mac_i  (viol_mac_i),
    .pvec_i (viol_pvec_i),
    .spid_i (viol_spid_i),
    .push_o (push),
    .ev_o   (ev)
  );

  atu_viol_queue u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .ev_i       (ev),
    .pop_i      (pop),
    .head_vld_o (head_vld),
    .head_o     (head),
    .ovf_o      (ovf_o)
  );

  atu_viol_cmd #(.CMD_LAT(CMD_LAT)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_i),
    .head_vld_i (head_vld),
    .head_i     (head),
    .busy_o     (busy_o),
    .pop_o      (pop),
    .res_o      (res)
  );

  assign irq_o   = head_vld;
  assign flags_o = res.kinds;
  assign mac_o   = res.mac;
  assign pvec_o  = res.pvec;
  assign spid_o  = res.spid;

  p_irq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) (|viol_kind_i) |=> irq_o);
  p_irq_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $fell(busy_o));
endmodule

// File: tb/atu_viol_capture_tb.sv
module atu_viol_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  kind = '0;
  logic [47:0] mac = '0;
  logic [10:0] pvec = '0;
  logic [3:0]  spid = '0;
  logic        cmd = 1'b0;
  logic        busy, irq, ovf;
  logic [3:0]  flags, spid_r;
  logic [47:0] mac_r;
  logic [10:0] pvec_r;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  logic [3:0]  q_k [2];
  logic [47:0] q_m [2];
  logic [10:0] q_p [2];
  logic [3:0]  q_s [2];
  int          q_n;
  logic        m_busy, m_ovf;
  int          m_cnt;
  logic [3:0]  r_k, r_s;
  logic [47:0] r_m;
  logic [10:0] r_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  atu_viol_capture #(.CMD_LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .viol_kind_i(kind), .viol_mac_i(mac),
    .viol_pvec_i(pvec), .viol_spid_i(spid), .cmd_i(cmd), .busy_o(busy),
    .irq_o(irq), .flags_o(flags), .mac_o(mac_r), .pvec_o(pvec_r),
    .spid_o(spid_r), .ovf_o(ovf)
  );

  task automatic model_reset();
    q_n = 0; m_busy = 0; m_ovf = 0; m_cnt = 0;
    r_k = '0; r_s = '0; r_m = '0; r_p = '0;
    for (int i = 0; i < 2; i++) begin
      q_k[i] = '0; q_m[i] = '0; q_p[i] = '0; q_s[i] = '0;
    end
  endtask

  task automatic compare(string tag);
    n_chk++;
    if (busy !== m_busy) begin
      n_fail++; $display("FAIL %s R3 busy act=%0b exp=%0b", tag, busy, m_busy);
    end
    if (irq !== (q_n > 0)) begin
      n_fail++; $display("FAIL %s R2/R8 irq act=%0b exp=%0b", tag, irq, q_n > 0);
    end
    if (ovf !== m_ovf) begin
      n_fail++; $display("FAIL %s R7 ovf act=%0b exp=%0b", tag, ovf, m_ovf);
    end
    if (flags !== r_k) begin
      n_fail++; $display("FAIL %s R4 flags act=%h exp=%h", tag, flags, r_k);
    end
    if (mac_r !== r_m || pvec_r !== r_p || spid_r !== r_s) begin
      n_fail++; $display("FAIL %s R4 fields act=%h/%h/%h exp=%h/%h/%h", tag,
                         mac_r, pvec_r, spid_r, r_m, r_p, r_s);
    end
  endtask

  // one clock: drive at negedge, update model, compare after posedge
  task automatic tick(input logic [3:0] k, input logic c, input string tag);
    logic fin;
    @(negedge clk);
    kind = k; cmd = c;
    mac = {$urandom, $urandom}; pvec = 11'($urandom); spid = 4'($urandom);
    fin = m_busy && m_cnt == 0;
    if (fin) begin
      if (q_n > 0) begin
        r_k = q_k[0]; r_m = q_m[0]; r_p = q_p[0]; r_s = q_s[0];
        q_k[0] = q_k[1]; q_m[0] = q_m[1]; q_p[0] = q_p[1]; q_s[0] = q_s[1];
        q_n--;
      end else begin
        r_k = '0; r_m = '0; r_p = '0; r_s = '0;
      end
      m_busy = 0;
    end else if (m_busy) m_cnt--;
    else if (c) begin m_busy = 1; m_cnt = LAT - 1; end
    if (k != 0) begin
      if (q_n < 2) begin
        q_k[q_n] = k; q_m[q_n] = mac; q_p[q_n] = pvec; q_s[q_n] = spid; q_n++;
      end else m_ovf = 1;
    end
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; kind = '0; cmd = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1 compare("R1 reset");
  endtask

  task automatic read_out(input string tag);
    tick(4'h0, 1'b1, tag);
    for (int i = 0; i < LAT; i++) tick(4'h0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    tick(4'b0010, 1'b0, "R2 member pulse");
    tick(4'b0100, 1'b0, "R6 second held");
    read_out("R4 first report");
    read_out("R6 second report");
    tick(4'h0, 1'b0, "R8 irq low");
    read_out("R9 empty command");
    tick(4'b1111, 1'b0, "R5 all kinds");
    read_out("R5 merged report");
    tick(4'b0001, 1'b0, "R7 fill a");
    tick(4'b1000, 1'b1, "R3 cmd accepted");
    tick(4'h0, 1'b1, "R3 cmd while busy");
    tick(4'b0100, 1'b0, "R7 overflow drop");
    tick(4'b0010, 1'b0, "R11 same-cycle push");
    repeat (3) tick(4'b0001, 1'b0, "R10 hold while idle");
    read_out("R11 next report");
    read_out("R6 drain");
    read_out("R7 ovf sticky");
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] k;
      k = ($urandom % 5 == 0) ? 4'($urandom) : 4'h0;
      tick(k, ($urandom % 3) == 0, "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule